// File: doc/BRIEF.md
# Iterative CORDIC Four-Quadrant Phase Detector

This block turns one in-phase/quadrature sample pair into a signed phase word, as the phase error detector of a tan-lock style digital loop needs. Both samples are taken at the same instant and handed over with a one-cycle start strobe. The block first folds the vector into the right half-plane with a quarter-turn pre-rotation. It then runs one shift-and-add micro-rotation per clock, which drives the quadrature coordinate toward zero and adds up the angles it turns through. The angle steps come from a small table of arctangent constants that is computed when the design is elaborated.

The result is a two's-complement word in which full scale stands for half a turn. The value 2^(PHASE_W-1) is π and wraps to −π. It appears together with a one-cycle done strobe a fixed number of cycles after the start. With the defaults (16-bit samples, 16-bit phase, 9 micro-rotations) the result is ready 9 clock edges after the accepting edge, inside the eleven-cycle budget. The phase word holds its value until the next result replaces it.

Top module: `cordic_phase_detector`

## Requirements
- R1: After a computation, `phase` equals atan2(sampleQ, sampleI) scaled by 2^(PHASE_W-1)/π, compared modulo 2^PHASE_W. The tolerance is 64 LSB for defaults, provided the larger of |I| and |Q| is at least 1024.
- R2: `done` is high for exactly one cycle. It rises after the ITERS-th rising edge that follows the edge accepting `start`: 9 edges by default, and never more than 11.
- R3: A `start` pulse that arrives while a computation is running is ignored. No extra `done` pulse follows it, and the result is not disturbed.
- R4: The input pair (0, 0) yields `phase` = 0 exactly.
- R5: A sample on the positive real axis (I > 0, Q = 0) yields `phase` = 0 exactly. A sample on the other axes yields +2^(PHASE_W-2), −2^(PHASE_W-2) or ±2^(PHASE_W-1), each within the R1 tolerance.
- R6: `phase` keeps its value in every cycle in which `done` is low.
- R7: While `rst` is high and after it falls, `done` is 0 and `phase` is 0 until the first result.
- R8: `sampleI` and `sampleQ` are captured only on the accepting edge. Changing them during a computation does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe; accepted only when idle |
| sampleI | input | DATA_W | Signed in-phase sample |
| sampleQ | input | DATA_W | Signed quadrature sample |
| done | output | 1 | One-cycle strobe marking a fresh phase word |
| phase | output | PHASE_W | Signed phase, full scale ±π |

## Verification
The assertions assume that `rst` is synchronous and that the I/Q pair only has meaning on the edge where `start` is accepted. This lets the checker keep its own model of the accepting edge and the countdown to `done`. Exact-zero checks only fire for inputs captured on that edge. The stimulus drives every input on the falling edge and holds `start` high for single cycles only. It deliberately changes the samples and pulses `start` in the middle of a run, to show that those inputs are ignored. Random pairs are drawn with a minimum magnitude of 1024, so that the accuracy tolerance applies.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture samples and apply quadrant fold
    logic step;    // perform one micro-rotation
    logic finish;  // last micro-rotation: latch the result
  } cordicCtl_t;

  // arctangent of 2^-step, in phase units where 2^(phaseW-1) is pi
  function automatic int atanUnits(input int step, input int phaseW);
    real x;
    real term;
    real sum;
    real scale;
    x = 1.0;
    for (int k = 0; k < step; k++) x = x / 2.0;
    if (step == 0) begin
      sum = PI_R / 4.0;
    end else begin
      sum  = 0.0;
      term = x;
      for (int k = 0; k < 14; k++) begin
        if ((k % 2) == 0) sum = sum + term / real'(2 * k + 1);
        else              sum = sum - term / real'(2 * k + 1);
        term = term * x * x;
      end
    end
    scale = 1.0;
    for (int k = 0; k < phaseW - 1; k++) scale = scale * 2.0;
    return $rtoi(sum * scale / PI_R + 0.5);
  endfunction

endpackage

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom #(
  parameter int PHASE_W = 16,
  parameter int ITERS   = 9,
  parameter int IDX_W   = 4
) (
  input  logic [IDX_W-1:0]          idx,
  output logic signed [PHASE_W-1:0] angle
);
  import cordic_pkg::*;

  logic signed [PHASE_W-1:0] angleTab [ITERS];

  for (genvar g = 0; g < ITERS; g++) begin : g_tab
    localparam int STEP_VAL = atanUnits(g, PHASE_W);
    assign angleTab[g] = PHASE_W'(STEP_VAL);
  end

  always_comb begin
    angle = '0;
    for (int k = 0; k < ITERS; k++) begin
      if (int'(idx) == k) angle = angleTab[k];
    end
  end

endmodule

// File: rtl/cordic_atan_ctrl.sv
module cordic_atan_ctrl #(
  parameter int ITERS = 9,
  parameter int IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output cordic_pkg::cordicCtl_t  ctl,
  output logic [IDX_W-1:0]        idx,
  output logic                    doneOut
);
  import cordic_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ITERS - 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_t;

  ctlState_t state;
  logic [IDX_W-1:0] idxR;

  always_comb begin
    ctl.load   = (state == ST_IDLE) && start;
    ctl.step   = (state == ST_RUN);
    ctl.finish = (state == ST_RUN) && (idxR == LAST_IDX);
  end

  assign idx = idxR;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idxR    <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            idxR  <= '0;
          end
        end
        ST_RUN: begin
          if (idxR == LAST_IDX) begin
            state   <= ST_IDLE;
            idxR    <= '0;
            doneOut <= 1'b1;
          end else begin
            idxR <= idxR + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cordic_atan_dp.sv
module cordic_atan_dp #(
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 16,
  parameter int ITERS   = 9,
  parameter int GUARD   = 4,
  parameter int IDX_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  cordic_pkg::cordicCtl_t     ctl,
  input  logic [IDX_W-1:0]           idx,
  input  logic signed [DATA_W-1:0]   sampleI,
  input  logic signed [DATA_W-1:0]   sampleQ,
  output logic signed [PHASE_W-1:0]  phase
);
  import cordic_pkg::*;

  // two growth bits (gain ~1.65 plus negation headroom) and guard LSBs
  localparam int W = DATA_W + 2 + GUARD;
  localparam logic signed [PHASE_W-1:0] QUARTER =
    {2'b01, {(PHASE_W-2){1'b0}}};

  logic signed [W-1:0] xExt, yExt;
  logic signed [W-1:0] xPre, yPre;
  logic signed [PHASE_W-1:0] zPre;
  logic signed [W-1:0] xR, yR, xNext, yNext;
  logic signed [PHASE_W-1:0] zR, zNext;
  logic signed [PHASE_W-1:0] stepAngle;
  logic signed [PHASE_W-1:0] resultR;

  cordic_atan_rom #(
    .PHASE_W(PHASE_W),
    .ITERS  (ITERS),
    .IDX_W  (IDX_W)
  ) u_rom (
    .idx  (idx),
    .angle(stepAngle)
  );

  assign xExt = $signed({{(W-DATA_W-GUARD){sampleI[DATA_W-1]}}, sampleI, {GUARD{1'b0}}});
  assign yExt = $signed({{(W-DATA_W-GUARD){sampleQ[DATA_W-1]}}, sampleQ, {GUARD{1'b0}}});

  // fold left half-plane vectors into the right half by a quarter turn
  always_comb begin
    if (xExt[W-1]) begin
      if (!yExt[W-1]) begin
        xPre = yExt;
        yPre = -xExt;
        zPre = QUARTER;
      end else begin
        xPre = -yExt;
        yPre = xExt;
        zPre = -QUARTER;
      end
    end else begin
      xPre = xExt;
      yPre = yExt;
      zPre = '0;
    end
  end

  // one vectoring micro-rotation; an exactly zero residual stops turning
  always_comb begin
    if (yR == '0) begin
      xNext = xR;
      yNext = yR;
      zNext = zR;
    end else if (!yR[W-1]) begin
      xNext = xR + (yR >>> idx);
      yNext = yR - (xR >>> idx);
      zNext = zR + stepAngle;
    end else begin
      xNext = xR - (yR >>> idx);
      yNext = yR + (xR >>> idx);
      zNext = zR - stepAngle;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xR      <= '0;
      yR      <= '0;
      zR      <= '0;
      resultR <= '0;
    end else begin
      if (ctl.load) begin
        xR <= xPre;
        yR <= yPre;
        zR <= zPre;
      end else if (ctl.step) begin
        xR <= xNext;
        yR <= yNext;
        zR <= zNext;
      end
      if (ctl.finish) resultR <= zNext;
    end
  end

  assign phase = resultR;

endmodule

// File: rtl/cordic_phase_detector.sv
module cordic_phase_detector #(
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 16,
  parameter int ITERS   = 9,
  parameter int GUARD   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic signed [DATA_W-1:0]  sampleI,
  input  logic signed [DATA_W-1:0]  sampleQ,
  output logic                      done,
  output logic signed [PHASE_W-1:0] phase
);
  import cordic_pkg::*;

  localparam int IDX_W = (ITERS > 1) ? $clog2(ITERS) : 1;

  cordicCtl_t       ctl;
  logic [IDX_W-1:0] idx;

  cordic_atan_ctrl #(
    .ITERS(ITERS),
    .IDX_W(IDX_W)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .ctl    (ctl),
    .idx    (idx),
    .doneOut(done)
  );

  cordic_atan_dp #(
    .DATA_W (DATA_W),
    .PHASE_W(PHASE_W),
    .ITERS  (ITERS),
    .GUARD  (GUARD),
    .IDX_W  (IDX_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .idx    (idx),
    .sampleI(sampleI),
    .sampleQ(sampleQ),
    .phase  (phase)
  );

endmodule

// File: rtl/cordic_phase_detector_chk.sv
module cordic_phase_detector_chk #(
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 16,
  parameter int ITERS   = 9
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      start,
  input logic signed [DATA_W-1:0]  sampleI,
  input logic signed [DATA_W-1:0]  sampleQ,
  input logic                      done,
  input logic signed [PHASE_W-1:0] phase
);
  localparam int CNT_W = $clog2(ITERS + 1);

  logic [CNT_W-1:0] remain;
  logic             doneExp;
  logic             zeroPend;
  logic             posAxisPend;
  logic             accept;

  assign accept = (remain == '0) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain      <= '0;
      doneExp     <= 1'b0;
      zeroPend    <= 1'b0;
      posAxisPend <= 1'b0;
    end else begin
      doneExp <= (remain == CNT_W'(1));
      if (accept) begin
        remain      <= CNT_W'(ITERS);
        zeroPend    <= (sampleI == '0) && (sampleQ == '0);
        posAxisPend <= (sampleQ == '0) && !sampleI[DATA_W-1] && (sampleI != '0);
      end else if (remain != '0) begin
        remain <= remain - 1'b1;
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    done == doneExp);

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(phase));

  // R4
  zero_in_chk: assert property (@(posedge clk) disable iff (rst)
    (done && zeroPend) |-> (phase == '0));

  // R5
  pos_axis_chk: assert property (@(posedge clk) disable iff (rst)
    (done && posAxisPend) |-> (phase == '0));

endmodule

bind cordic_phase_detector cordic_phase_detector_chk #(
  .DATA_W (DATA_W),
  .PHASE_W(PHASE_W),
  .ITERS  (ITERS)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .sampleI(sampleI),
  .sampleQ(sampleQ),
  .done   (done),
  .phase  (phase)
);

// File: tb/cordic_phase_detector_tb.sv
module cordic_phase_detector_tb;
  localparam int  DATA_W  = 16;
  localparam int  PHASE_W = 16;
  localparam int  ITERS   = 9;
  localparam int  TOL     = 64;
  localparam real PI_B    = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [DATA_W-1:0]  sampleI = '0;
  logic signed [DATA_W-1:0]  sampleQ = '0;
  logic                      done;
  logic signed [PHASE_W-1:0] phase;

  int nChecks = 0;
  int nFail   = 0;
  bit ended   = 1'b0;

  always #5 clk = ~clk;

  cordic_phase_detector #(
    .DATA_W(DATA_W), .PHASE_W(PHASE_W), .ITERS(ITERS)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start),
    .sampleI(sampleI), .sampleQ(sampleQ),
    .done(done), .phase(phase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expPhase(input int i, input int q);
    real a;
    if (i == 0 && q == 0) return 0;
    a = $atan2(real'(q), real'(i));
    return $rtoi($floor(a * 32768.0 / PI_B + 0.5));
  endfunction

  function automatic int angDiff(input int got, input int exp);
    logic signed [15:0] d;
    d = 16'(got - exp);
    return (d < 0) ? -int'(d) : int'(d);
  endfunction

  // runs one sample pair; exact selects exact compare
  task automatic runOne(input int i, input int q, input bit exact, input string req);
    int lat;
    int got;
    int exp;
    int held;
    @(negedge clk);
    sampleI = DATA_W'(i);
    sampleQ = DATA_W'(q);
    start   = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        start = 1'b0;
        // R8: disturb the samples after capture
        sampleI = ~sampleI;
        sampleQ = DATA_W'($urandom);
      end
    end while (!done && lat < 20);
    // R2: done seen at the negedge after ITERS edges past the accepting edge
    check(lat == ITERS + 1, "R2 latency", lat, ITERS + 1);
    got = int'(phase);
    exp = expPhase(i, q);
    if (exact) check(got == exp, req, got, exp);
    else       check(angDiff(got, exp) <= TOL, req, got, exp);
    held = got;
    @(negedge clk);
    check(done == 1'b0, "R2 single pulse", int'(done), 0);
    check(int'(phase) == held, "R6 hold", int'(phase), held);
  endtask

  initial begin
    int a;
    int b;
    int lat;
    int extra;
    int got;
    void'($urandom(32'd20240611));

    // R7 reset state
    repeat (5) @(negedge clk);
    check(done == 1'b0, "R7 done in reset", int'(done), 0);
    check(int'(phase) == 0, "R7 phase in reset", int'(phase), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R7 done after reset", int'(done), 0);
    check(int'(phase) == 0, "R7 phase after reset", int'(phase), 0);

    // R4 zero vector
    runOne(0, 0, 1'b1, "R4 zero input");
    // R5 axes
    runOne(5000, 0, 1'b1, "R5 positive real axis");
    runOne(0, 5000, 1'b0, "R5 positive imag axis");
    runOne(0, -5000, 1'b0, "R5 negative imag axis");
    runOne(-5000, 0, 1'b0, "R5 negative real axis");
    runOne(-32768, 0, 1'b0, "R5 negative real full scale");
    // R1 directed corners
    runOne(32767, 32767, 1'b0, "R1 first diagonal");
    runOne(-32768, -32768, 1'b0, "R1 third diagonal");
    runOne(-32768, 1, 1'b0, "R1 near plus pi");
    runOne(-32768, -1, 1'b0, "R1 near minus pi");
    runOne(1024, -32768, 1'b0, "R1 steep fourth quadrant");

    // R3 and R8: start while busy is ignored
    @(negedge clk);
    sampleI = 16'sd3000;
    sampleQ = -16'sd7000;
    start   = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      start = 1'b0;
      if (lat == 3) begin
        start   = 1'b1;
        sampleI = -16'sd9000;
        sampleQ = 16'sd9000;
      end
    end while (!done && lat < 20);
    start = 1'b0;
    check(lat == ITERS + 1, "R3 latency with busy start", lat, ITERS + 1);
    got = int'(phase);
    check(angDiff(got, expPhase(3000, -7000)) <= TOL, "R3 result from first sample",
          got, expPhase(3000, -7000));
    extra = 0;
    repeat (ITERS + 4) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R3 no extra done", extra, 0);

    // R1 random pairs
    for (int n = 0; n < 150; n++) begin
      do begin
        a = int'($signed(16'($urandom)));
        b = int'($signed(16'($urandom)));
      end while (((a < 0 ? -a : a) < 1024) && ((b < 0 ? -b : b) < 1024));
      runOne(a, b, 1'b0, "R1 random pair");
    end

    ended = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      nChecks++;
      nFail++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule